// File: doc/BRIEF.md
# Scanline Table Sequencer

This block feeds per-scanline register updates to a display unit through a small set of parallel channels. Each channel walks its own list of entries in a byte-wide memory. An entry starts with a header byte. The low seven bits of the header give a number of lines, and the top bit says whether the payload repeats on every one of those lines or is sent only on the first. In direct mode the payload bytes sit in the list right after the header. In indirect mode the header is followed by a 16-bit pointer, low byte first, and the payload is fetched from the address it names.

A frame pulse rewinds every enabled channel to its base address and loads its first entry. Each line pulse then runs the channels in two passes. The first pass moves payload bytes for every channel that is due to move them, in ascending channel order, towards destination addresses formed from the channel's destination base plus a lane offset that depends on the channel mode. The second pass counts lines down and fetches new entries. A header of zero stops a channel until the next frame pulse. Every memory access takes one clock.

Top module: `hblank_table_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `memRd` and `bWr` are all 0.
- R2: A line pulse is ignored while `enMask` is zero, and also while the block is busy. Neither memory port is touched and `busy` stays low.
- R3: On a frame pulse, each enabled channel reads its first header at its base address. A zero header gives no payload and no further reads for that channel until the next frame pulse.
- R4: In indirect mode, the frame pulse also reads a pointer, low byte first and then high byte. Payload bytes are then read from the pointer, which steps up by one per byte.
- R5: The number of payload bytes per line depends on mode 0..7 and is 1,2,2,4,4,4,2,4. The lane offsets added to the destination base are, per mode: 0 | 0,1 | 0,0 | 0,0,1,1 | 0,1,2,3 | 0,1,0,1 | 0,0 | 0,0,1,1.
- R6: In direct mode the payload bytes are read from the list right after the header, and the list address advances one byte per payload byte.
- R7: A header with bit 7 set sends a payload on each of its counted lines. With bit 7 clear, a payload is sent only on the first line.
- R8: Within a line, every payload transfer of every channel comes before any header or pointer fetch, and channels are served in ascending index order.
- R9: Each active channel reads one list byte during the update pass of every line, even when that byte is not used as a new header.
- R10: When an indirect channel loads a zero header during a line and no higher-numbered enabled channel is still active, only one pointer byte is read. Otherwise two are read.
- R11: A channel stopped by a zero header restarts from its base address on the next frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameP | input | 1 | Frame start pulse |
| lineP | input | 1 | Scanline pulse |
| enMask | input | NCH | Channel enable mask |
| cfgIndirect | input | NCH | Per-channel indirect mode |
| cfgMode | input | 3*NCH | Per-channel transfer mode |
| cfgDest | input | 8*NCH | Per-channel destination base |
| cfgBase | input | 16*NCH | Per-channel list base address |
| memAddr | output | 16 | Memory read address |
| memRd | output | 1 | Memory read strobe |
| memRdata | input | 8 | Memory read data, valid in the same cycle |
| bWr | output | 1 | Destination write strobe |
| bAddr | output | 8 | Destination address |
| bData | output | 8 | Destination write data |
| busy | output | 1 | A frame or line pass is in progress |

## Verification
The bench builds the block with the default eight channels. This lets one indirect channel run either alone or beneath an active higher-numbered channel, and so reach both sides of the single-pointer-byte case. With a 256-byte memory model, every list, pointer target and zero terminator fits in one page. Each of the eight modes is driven through the same direct-mode list, so that byte counts and lane offsets can be compared mode by mode.

// File: rtl/hts_pkg.sv
package hts_pkg;
  localparam int PTR_W = 16;

  typedef struct packed {
    logic initClr;
    logic loadBase;
    logic hdrLd;
    logic ctrDec;
    logic ptrLo;
    logic ptrHi;
    logic zeroLo;
    logic xferStep;
  } hts_strobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PICK_I, ST_I_HDR, ST_I_LO, ST_I_HI,
    ST_PICK_X, ST_X_BYTE, ST_PICK_U, ST_U_HDR, ST_U_LO, ST_U_HI
  } hts_state_t;

  function automatic logic [2:0] bytesPerLine(input logic [2:0] mode);
    case (mode)
      3'd0: bytesPerLine = 3'd1;
      3'd1, 3'd2, 3'd6: bytesPerLine = 3'd2;
      default: bytesPerLine = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] laneOffset(input logic [2:0] mode, input logic [1:0] idx);
    case (mode)
      3'd1, 3'd5: laneOffset = {1'b0, idx[0]};
      3'd3, 3'd7: laneOffset = {1'b0, idx[1]};
      3'd4: laneOffset = idx;
      default: laneOffset = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/hts_chan_state.sv
module hts_chan_state
  import hts_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hts_strobe_t          st,
  input  logic [CHW-1:0]       ch,
  input  logic [NCH-1:0]       enMask,
  input  logic [NCH-1:0]       cfgIndirect,
  input  logic [NCH*PTR_W-1:0] cfgBase,
  input  logic [7:0]           rdData,
  output logic [NCH-1:0]       doneVec,
  output logic [NCH-1:0]       xferVec,
  output logic [PTR_W-1:0]     curTbl,
  output logic [PTR_W-1:0]     curInd,
  output logic [7:0]           curCtr
);
  logic [PTR_W-1:0] tblW [NCH];
  logic [PTR_W-1:0] indW [NCH];
  logic [7:0]       ctrW [NCH];

  for (genvar g = 0; g < NCH; g++) begin : gCh
    localparam logic [CHW-1:0] ID = CHW'(g);
    logic sel;
    logic [PTR_W-1:0] tblR, indR;
    logic [7:0] ctrR, decV;
    logic doneR, xferR;
    assign sel  = (ch == ID);
    assign decV = ctrR - 8'd1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tblR <= '0; indR <= '0; ctrR <= '0; doneR <= 1'b0; xferR <= 1'b0;
      end else if (st.initClr) begin
        doneR <= 1'b0;
        xferR <= |enMask;
        if (st.loadBase && enMask[g]) tblR <= cfgBase[g*PTR_W +: PTR_W];
      end else if (sel) begin
        if (st.hdrLd) begin
          ctrR  <= rdData;
          tblR  <= tblR + 1'b1;
          doneR <= (rdData == 8'h00);
          xferR <= 1'b1;
        end else if (st.ctrDec) begin
          ctrR  <= decV;
          xferR <= decV[7];
        end else if (st.ptrLo) begin
          indR[7:0] <= rdData;
          tblR      <= tblR + 1'b1;
        end else if (st.ptrHi) begin
          indR[15:8] <= rdData;
          if (st.zeroLo) indR[7:0] <= 8'h00;
          tblR       <= tblR + 1'b1;
        end else if (st.xferStep) begin
          if (cfgIndirect[g]) indR <= indR + 1'b1;
          else                tblR <= tblR + 1'b1;
        end
      end
    end

    assign tblW[g]    = tblR;
    assign indW[g]    = indR;
    assign ctrW[g]    = ctrR;
    assign doneVec[g] = doneR;
    assign xferVec[g] = xferR;
  end

  assign curTbl = tblW[ch];
  assign curInd = indW[ch];
  assign curCtr = ctrW[ch];

  // R3
  done_on_zero_hdr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.hdrLd && rdData == 8'h00) |=> doneVec[$past(ch)]);

  // R3
  no_step_when_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.xferStep |-> (!doneVec[ch] && xferVec[ch] && enMask[ch]));

  // R10
  zero_low_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.ptrHi && st.zeroLo) |=> (curInd[7:0] == 8'h00));
endmodule

// File: rtl/hts_ctrl.sv
module hts_ctrl
  import hts_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameP,
  input  logic               lineP,
  input  logic [NCH-1:0]     enMask,
  input  logic [NCH-1:0]     cfgIndirect,
  input  logic [NCH*3-1:0]   cfgMode,
  input  logic [NCH*8-1:0]   cfgDest,
  input  logic [NCH-1:0]     doneVec,
  input  logic [NCH-1:0]     xferVec,
  input  logic [PTR_W-1:0]   curTbl,
  input  logic [PTR_W-1:0]   curInd,
  input  logic [7:0]         curCtr,
  input  logic [7:0]         rdData,
  output hts_strobe_t        st,
  output logic [CHW-1:0]     ch,
  output logic [PTR_W-1:0]   memAddr,
  output logic               memRd,
  output logic               bWr,
  output logic [7:0]         bAddr,
  output logic [7:0]         bData,
  output logic               busy
);
  hts_state_t state, nxt;
  logic [CHW-1:0] chN;
  logic [CHW:0]   scanFrom, scanN;
  logic [1:0]     bi, biN;
  logic           quirkQ, quirkN;

  logic [NCH-1:0] elig;
  logic           found, lastAct;
  logic [CHW-1:0] idx;
  logic [2:0]     curMode, curCnt;
  logic [7:0]     curDest, decV;
  logic           curIndSel;

  assign curMode   = cfgMode[int'(ch)*3 +: 3];
  assign curDest   = cfgDest[int'(ch)*8 +: 8];
  assign curIndSel = cfgIndirect[ch];
  assign curCnt    = bytesPerLine(curMode);
  assign decV      = curCtr - 8'd1;

  always_comb begin
    case (state)
      ST_PICK_I: elig = enMask;
      ST_PICK_X: elig = enMask & ~doneVec & xferVec;
      default:   elig = enMask & ~doneVec;
    endcase
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (elig[i] && i >= int'(scanFrom)) begin
        found = 1'b1;
        idx   = i[CHW-1:0];
      end
    end
    lastAct = 1'b1;
    for (int i = 0; i < NCH; i++) begin
      if (i > int'(ch) && enMask[i] && !doneVec[i]) lastAct = 1'b0;
    end
  end

  always_comb begin
    nxt = state; chN = ch; scanN = scanFrom; biN = bi; quirkN = quirkQ;
    st = '0; memRd = 1'b0; bWr = 1'b0;
    case (state)
      ST_IDLE: begin
        quirkN = 1'b0;
        if (frameP) begin
          st.initClr = 1'b1; st.loadBase = 1'b1;
          scanN = '0; nxt = ST_PICK_I;
        end else if (lineP && |enMask) begin
          scanN = '0; nxt = ST_PICK_X;
        end
      end
      ST_PICK_I: if (found) begin chN = idx; nxt = ST_I_HDR; end
                 else nxt = ST_IDLE;
      ST_I_HDR: begin
        memRd = 1'b1; st.hdrLd = 1'b1; scanN = {1'b0, ch} + 1'b1;
        nxt = curIndSel ? ST_I_LO : ST_PICK_I;
      end
      ST_I_LO: begin memRd = 1'b1; st.ptrLo = 1'b1; nxt = ST_I_HI; end
      ST_I_HI: begin memRd = 1'b1; st.ptrHi = 1'b1; nxt = ST_PICK_I; end
      ST_PICK_X: if (found) begin chN = idx; biN = '0; nxt = ST_X_BYTE; end
                 else begin scanN = '0; nxt = ST_PICK_U; end
      ST_X_BYTE: begin
        memRd = 1'b1; bWr = 1'b1; st.xferStep = 1'b1;
        if ({1'b0, bi} == curCnt - 3'd1) begin
          scanN = {1'b0, ch} + 1'b1; nxt = ST_PICK_X;
        end else biN = bi + 2'd1;
      end
      ST_PICK_U: if (found) begin chN = idx; nxt = ST_U_HDR; end
                 else nxt = ST_IDLE;
      ST_U_HDR: begin
        memRd = 1'b1; scanN = {1'b0, ch} + 1'b1;
        if (decV[6:0] != 7'd0) begin
          st.ctrDec = 1'b1; nxt = ST_PICK_U;
        end else begin
          st.hdrLd = 1'b1;
          if (!curIndSel) nxt = ST_PICK_U;
          else if (rdData == 8'h00 && lastAct) begin quirkN = 1'b1; nxt = ST_U_HI; end
          else begin quirkN = 1'b0; nxt = ST_U_LO; end
        end
      end
      ST_U_LO: begin memRd = 1'b1; st.ptrLo = 1'b1; nxt = ST_U_HI; end
      ST_U_HI: begin
        memRd = 1'b1; st.ptrHi = 1'b1; st.zeroLo = quirkQ; nxt = ST_PICK_U;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; ch <= '0; scanFrom <= '0; bi <= '0; quirkQ <= 1'b0;
    end else begin
      state <= nxt; ch <= chN; scanFrom <= scanN; bi <= biN; quirkQ <= quirkN;
    end
  end

  assign memAddr = (state == ST_X_BYTE && curIndSel) ? curInd : curTbl;
  assign bAddr   = curDest + {6'd0, laneOffset(curMode, bi)};
  assign bData   = rdData;
  assign busy    = (state != ST_IDLE);

  // R2
  line_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && lineP && !frameP && enMask == '0) |=> !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memRd && !bWr));

  // R5
  write_has_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    bWr |-> memRd);
endmodule

// File: rtl/hblank_table_seq.sv
module hblank_table_seq
  import hts_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameP,
  input  logic                 lineP,
  input  logic [NCH-1:0]       enMask,
  input  logic [NCH-1:0]       cfgIndirect,
  input  logic [NCH*3-1:0]     cfgMode,
  input  logic [NCH*8-1:0]     cfgDest,
  input  logic [NCH*PTR_W-1:0] cfgBase,
  output logic [PTR_W-1:0]     memAddr,
  output logic                 memRd,
  input  logic [7:0]           memRdata,
  output logic                 bWr,
  output logic [7:0]           bAddr,
  output logic [7:0]           bData,
  output logic                 busy
);
  localparam int CHW = $clog2(NCH);

  hts_strobe_t      st;
  logic [CHW-1:0]   ch;
  logic [NCH-1:0]   doneVec, xferVec;
  logic [PTR_W-1:0] curTbl, curInd;
  logic [7:0]       curCtr;

  hts_ctrl #(.NCH(NCH)) uCtrl (
    .clk(clk), .rstN(rstN), .frameP(frameP), .lineP(lineP), .enMask(enMask),
    .cfgIndirect(cfgIndirect), .cfgMode(cfgMode), .cfgDest(cfgDest),
    .doneVec(doneVec), .xferVec(xferVec), .curTbl(curTbl), .curInd(curInd),
    .curCtr(curCtr), .rdData(memRdata), .st(st), .ch(ch), .memAddr(memAddr),
    .memRd(memRd), .bWr(bWr), .bAddr(bAddr), .bData(bData), .busy(busy)
  );

  hts_chan_state #(.NCH(NCH)) uState (
    .clk(clk), .rstN(rstN), .st(st), .ch(ch), .enMask(enMask),
    .cfgIndirect(cfgIndirect), .cfgBase(cfgBase), .rdData(memRdata),
    .doneVec(doneVec), .xferVec(xferVec), .curTbl(curTbl), .curInd(curInd),
    .curCtr(curCtr)
  );
endmodule

// File: tb/sim_hblank_table_seq.sv
module sim_hblank_table_seq;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameP = 1'b0, lineP = 1'b0;
  logic [NCH-1:0] enMask = '0, cfgIndirect = '0;
  logic [NCH*3-1:0] cfgMode = '0;
  logic [NCH*8-1:0] cfgDest = '0;
  logic [NCH*16-1:0] cfgBase = '0;
  logic [15:0] memAddr;
  logic memRd, bWr, busy;
  logic [7:0] memRdata, bAddr, bData;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  assign memRdata = mem[memAddr[7:0]];

  hblank_table_seq #(.NCH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .frameP(frameP), .lineP(lineP), .enMask(enMask),
    .cfgIndirect(cfgIndirect), .cfgMode(cfgMode), .cfgDest(cfgDest),
    .cfgBase(cfgBase), .memAddr(memAddr), .memRd(memRd), .memRdata(memRdata),
    .bWr(bWr), .bAddr(bAddr), .bData(bData), .busy(busy)
  );

  int nChk = 0, nFail = 0;
  int rdCnt = 0, wrCnt = 0;
  logic sawFetch = 0, orderBad = 0;
  logic [7:0] wrA [16];
  logic [7:0] wrD [16];

  always @(negedge clk) begin
    if (memRd) rdCnt++;
    if (memRd && !bWr) sawFetch = 1'b1;
    if (bWr) begin
      if (sawFetch) orderBad = 1'b1;
      if (wrCnt < 16) begin wrA[wrCnt] = bAddr; wrD[wrCnt] = bData; end
      wrCnt++;
    end
  end

  // {mode, byte count, lane offsets lane3..lane0}
  localparam logic [13:0] VEC [8] = '{
    {3'd0, 3'd1, 8'h00}, {3'd1, 3'd2, 8'h04}, {3'd2, 3'd2, 8'h00},
    {3'd3, 3'd4, 8'h50}, {3'd4, 3'd4, 8'hE4}, {3'd5, 3'd4, 8'h44},
    {3'd6, 3'd2, 8'h00}, {3'd7, 3'd4, 8'h50}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    rdCnt = 0; wrCnt = 0; sawFetch = 1'b0; orderBad = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic doFrame();
    clearLog();
    @(negedge clk) frameP = 1'b1;
    @(negedge clk) frameP = 1'b0;
    waitIdle();
  endtask

  task automatic doLine();
    clearLog();
    @(negedge clk) lineP = 1'b1;
    @(negedge clk) lineP = 1'b0;
    waitIdle();
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
  endtask

  task automatic setCh(input int c, input logic [15:0] base, input logic [2:0] mode,
                       input logic ind, input logic [7:0] dest);
    cfgBase[c*16 +: 16] = base;
    cfgMode[c*3 +: 3]   = mode;
    cfgIndirect[c]      = ind;
    cfgDest[c*8 +: 8]   = dest;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual running expected idle");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 memRd", memRd, 0);
    check("R1 bWr", bWr, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 line pulse with empty mask
    setCh(0, 16'h0010, 3'd0, 1'b0, 8'h20);
    mem[8'h10] = 8'h81; mem[8'h11] = 8'h55;
    clearLog();
    @(negedge clk) lineP = 1'b1;
    @(negedge clk) lineP = 1'b0;
    check("R2 busy stays low", busy, 0);
    check("R2 no reads", rdCnt, 0);

    // R5 per-mode byte count and lanes
    for (int v = 0; v < 8; v++) begin
      logic [2:0] m; logic [2:0] n; logic [7:0] offs; logic ok;
      {m, n, offs} = VEC[v];
      clearMem();
      mem[8'h10] = 8'h01;
      for (int k = 0; k < 4; k++) mem[8'h11 + k] = 8'hA0 + 8'(k);
      enMask = 8'h01;
      setCh(0, 16'h0010, m, 1'b0, 8'h20);
      doFrame();
      doLine();
      check("R5 byte count", wrCnt, n);
      ok = 1'b1;
      for (int k = 0; k < 4; k++)
        if (k < int'(n))
          if (wrA[k] !== 8'h20 + {6'd0, offs[2*k +: 2]} || wrD[k] !== 8'hA0 + 8'(k)) ok = 1'b0;
      check("R5 R6 lane pattern", ok, 1);
    end

    // R7 repeat header 0x83
    clearMem();
    mem[8'h10] = 8'h83; mem[8'h11] = 8'hB0; mem[8'h12] = 8'hB1; mem[8'h13] = 8'hB2;
    setCh(0, 16'h0010, 3'd0, 1'b0, 8'h20);
    enMask = 8'h01;
    doFrame();
    for (int l = 0; l < 4; l++) begin
      doLine();
      check("R7 repeat writes", wrCnt, (l < 3) ? 1 : 0);
      if (l < 3) check("R6 R7 repeat data", wrD[0], 8'hB0 + 8'(l));
    end

    // R7 R9 non-repeat header 0x03
    clearMem();
    mem[8'h10] = 8'h03; mem[8'h11] = 8'hB0;
    doFrame();
    doLine();
    check("R7 single write", wrCnt, 1);
    doLine();
    check("R7 no repeat", wrCnt, 0);
    check("R9 discarded read", rdCnt, 1);
    doLine();
    doLine();
    check("R3 stopped", rdCnt, 0);
    // R11 restart on next frame
    doFrame();
    doLine();
    check("R11 restart count", wrCnt, 1);
    check("R11 restart data", wrD[0], 8'hB0);

    // R3 zero header at frame start
    clearMem();
    doFrame();
    check("R3 frame reads", rdCnt, 1);
    doLine();
    check("R3 zero header writes", wrCnt, 0);
    check("R3 zero header reads", rdCnt, 0);

    // R8 two channels, transfers first, ascending order
    clearMem();
    mem[8'h10] = 8'h01; mem[8'h11] = 8'hC0; mem[8'h12] = 8'hC1;
    mem[8'h30] = 8'h01; mem[8'h31] = 8'hD0;
    setCh(0, 16'h0010, 3'd1, 1'b0, 8'h20);
    setCh(2, 16'h0030, 3'd0, 1'b0, 8'h40);
    enMask = 8'h05;
    doFrame();
    doLine();
    check("R8 order flag", orderBad, 0);
    check("R8 write count", wrCnt, 3);
    check("R8 first", {wrA[0], wrD[0]}, 16'h20C0);
    check("R8 second", {wrA[1], wrD[1]}, 16'h21C1);
    check("R8 third", {wrA[2], wrD[2]}, 16'h40D0);
    check("R9 line reads", rdCnt, 5);

    // R4 R10 indirect, last active channel
    clearMem();
    mem[8'h50] = 8'h82; mem[8'h51] = 8'h80; mem[8'h52] = 8'h00;
    mem[8'h53] = 8'h00; mem[8'h54] = 8'h77;
    mem[8'h80] = 8'hE0; mem[8'h81] = 8'hE1;
    mem[8'h70] = 8'h05; mem[8'h71] = 8'hF0;
    setCh(1, 16'h0050, 3'd0, 1'b1, 8'h60);
    setCh(3, 16'h0070, 3'd0, 1'b0, 8'h70);
    enMask = 8'h02;
    doFrame();
    check("R4 frame reads", rdCnt, 3);
    doLine();
    check("R4 indirect data", {wrA[0], wrD[0]}, 16'h60E0);
    doLine();
    check("R4 pointer steps", wrD[0], 8'hE1);
    check("R10 single pointer byte", rdCnt, 3);

    // R10 higher channel still active: two pointer bytes
    enMask = 8'h0A;
    doFrame();
    doLine();
    check("R10 line1 writes", wrCnt, 2);
    doLine();
    check("R10 two pointer bytes", rdCnt, 5);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule